// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns one 28-bit parallel pixel word per pixel period into four serial data lanes and one forwarded clock lane, each lane carrying seven bit slots per pixel period. The word holds 24 colour bits, a line sync bit, a frame sync bit, a data-ready bit and one spare bit. The pixel-to-bit assignment on the panel side is up to the integrator.

The block runs on a bit clock at seven times the pixel rate, phase-aligned with the pixel clock. It samples the pixel clock as an ordinary input and captures the word on the edge that a configuration input selects. A word captured on one selected edge goes out during the period that starts at the next selected edge, which gives a fixed latency of one pixel period. A power-down input forces every lane low and discards the pipeline state. Only the serial bit streams are modelled. Analog signalling and clock synthesis belong to other blocks.

Top module: `dlink_ser7_tx`

## Requirements
- R1: After reset, every lane output is low. The lanes stay low until a word has been captured and the following selected edge has started its transmission.
- R2: With `rise_sel_i`=1 the word on `data_i` is captured on a rising pixel-clock edge, and with `rise_sel_i`=0 on a falling edge. The other edge is ignored, and so are changes of `data_i` between captures.
- R3: Lane k sends bits 7k+6 down to 7k of the captured word, most significant first, so bit 7k+6 sits in slot 0 and bit 7k in slot 6.
- R4: A selected edge seen at bit-clock edge P puts slot n of the previous word on the lanes from bit-clock edge P+n to P+n+1. This is a latency of exactly one pixel period.
- R5: In every period that carries a word, the clock lane sends the slot pattern 1,1,0,0,0,1,1 (slot 0 first), which has one rising and one falling transition per period.
- R6: While `pd_i` is high, every lane output is low in the same cycle, whatever the pixel clock and data do.
- R7: After `pd_i` falls, the first period is sent all low, including the clock lane. The first word captured after release is sent from the next selected edge on.
- R8: Pixel periods of exactly seven bit clocks give back-to-back transmission with no idle slot between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_clk_i | input | 1 | Pixel clock, sampled on the bit clock |
| rise_sel_i | input | 1 | 1: capture on rising pixel edge, 0: on falling edge |
| pd_i | input | 1 | Power-down, forces all lanes low |
| data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock pattern lane |

## Verification
Power-down release and a capture edge can fall in the same bit-clock cycle. The bench provokes this by dropping `pd_i` on the same half-cycle in which it drives the selected pixel-clock edge, in falling-edge mode. The word offered at that edge must be captured: the bench expects one all-low period, clock lane included, and then exactly that word with the clock pattern on the following period. An ignored opposite edge, with `data_i` inverted in mid-period, runs in every period and must never change what is sent.

// File: rtl/dlink_ser7_tx.sv
module dlink_ser7_tx #(
  parameter int LANES = 4,
  parameter int SLOTS = 7,
  parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_clk_i,
  input  logic                   rise_sel_i,
  input  logic                   pd_i,
  input  logic [LANES*SLOTS-1:0] data_i,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o
);
  localparam int W = LANES * SLOTS;

  logic         pix_q;
  logic         cap;
  logic         hold_vld;
  logic [W-1:0] hold;
  logic [SLOTS-1:0] ck_sh;

  assign cap = rise_sel_i ? (pix_clk_i & ~pix_q) : (~pix_clk_i & pix_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q    <= 1'b0;
      hold     <= '0;
      hold_vld <= 1'b0;
    end else begin
      pix_q <= pix_clk_i;
      if (pd_i) begin
        hold_vld <= 1'b0;
      end else if (cap) begin
        hold     <= data_i;
        hold_vld <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          sh <= '0;
      else if (pd_i)        sh <= '0;
      else if (cap)         sh <= hold_vld ? hold[k*SLOTS +: SLOTS] : '0;
      else                  sh <= {sh[SLOTS-2:0], 1'b0};
    end
    assign lane_o[k] = sh[SLOTS-1] & ~pd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ck_sh <= '0;
    else if (pd_i)        ck_sh <= '0;
    else if (cap)         ck_sh <= hold_vld ? CLK_PAT : '0;
    else                  ck_sh <= {ck_sh[SLOTS-2:0], 1'b0};
  end
  assign clk_lane_o = ck_sh[SLOTS-1] & ~pd_i;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_vld |-> (lane_o == '0 && !clk_lane_o)); // R1

  AST_VLD_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_vld) |-> $past(cap)); // R2

  AST_CLK_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && hold_vld && !pd_i) |=> (clk_lane_o == CLK_PAT[SLOTS-1])); // R5

  AST_PD_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_i) && !pd_i) |-> (lane_o == '0 && !clk_lane_o)); // R7
endmodule

// File: tb/dlink_ser7_tx_tb.sv
module dlink_ser7_tx_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix = 1'b0;
  logic        sel = 1'b1;
  logic        pd = 1'b0;
  logic [27:0] din = '0;
  logic [3:0]  lane;
  logic        ckl;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [27:0] VEC [8] = '{
    28'h8102040, 28'h0204081, 28'hFFFFFFF, 28'h0000000,
    28'h5555555, 28'hAAAAAAA, 28'h1234567, 28'hFEDCBA9
  };
  localparam logic [6:0] PAT = 7'b1100011;

  always #4 clk = ~clk;

  dlink_ser7_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_clk_i(pix), .rise_sel_i(sel),
    .pd_i(pd), .data_i(din), .lane_o(lane), .clk_lane_o(ckl)
  );

  task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one pixel period: selected edge at start, ignored edge mid-period with inverted data
  task automatic period(input logic [27:0] word, output logic [27:0] obs, output logic [6:0] ck);
    pix = sel;
    din = word;
    obs = '0;
    ck = '0;
    for (int n = 0; n < 7; n++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) obs[7*k + 6 - n] = lane[k];
      ck[6-n] = ckl;
      if (n == 3) begin
        pix = ~sel;
        din = ~word;
      end
    end
  endtask

  task automatic run_and_check(input logic [27:0] word, input logic [27:0] exp, input bit exp_vld, input string req);
    logic [27:0] obs;
    logic [6:0]  ck;
    period(word, obs, ck);
    chk(obs == exp, req, obs, exp);
    chk(ck == (exp_vld ? PAT : 7'b0), "R5 clock lane", {21'b0, ck}, {21'b0, exp_vld ? PAT : 7'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(lane == 4'b0 && ckl == 1'b0, "R1 reset", {23'b0, ckl, lane}, '0);

    // rising mode, table walk; R3 R4 R8 back to back, R2 opposite edge ignored
    run_and_check(VEC[0], '0, 1'b0, "R1 first period low");
    for (int i = 1; i < 8; i++) run_and_check(VEC[i], VEC[i-1], 1'b1, "R3 R4 R2 rising");
    run_and_check(28'h0F0F0F0, VEC[7], 1'b1, "R8 back to back");

    // R6: power-down with pixel clock and data moving
    pd = 1'b1;
    for (int c = 0; c < 10; c++) begin
      pix = c[1];
      din = {28{c[0]}};
      @(negedge clk);
      chk(lane == 4'b0 && ckl == 1'b0, "R6 power-down low", {23'b0, ckl, lane}, '0);
    end
    sel = 1'b0;
    pix = 1'b1;
    @(negedge clk);
    chk(lane == 4'b0 && ckl == 1'b0, "R6 power-down low", {23'b0, ckl, lane}, '0);

    // R7: release coincides with falling capture edge
    pd = 1'b0;
    run_and_check(28'hC3A5F01, '0, 1'b0, "R7 first period low");
    run_and_check(VEC[0], 28'hC3A5F01, 1'b1, "R7 word at release edge");
    for (int i = 1; i < 8; i++) run_and_check(VEC[i], VEC[i-1], 1'b1, "R2 R3 falling");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule